// File: doc/BRIEF.md
# Block-Floating-Point Output Normaliser

This block brings the results of a block-floating-point FFT back to a single fixed scale. Each output sample of the transform is a complex pair of 16-bit two's-complement words. The real word arrives first and the imaginary word on a later cycle. The sample carries a 2-bit word tag. A 5-bit group exponent, loaded once per transform, applies to every word of that transform.

The block adds the tag to the group exponent to form the word exponent. It subtracts that from a programmable universal exponent and arithmetic-shifts the word right by the difference. Because the word exponent is a plain sum, software programs the universal exponent one above its nominal value. The shift count saturates at 15. A word whose exponent is above the universal exponent passes unshifted and raises a sticky overflow flag.

Both words of a sample share one shifter and one shift count. The imaginary word reuses the count formed from its real partner. The stream has a fixed two-cycle latency.

Top module: `bfp_out_norm`

## Requirements
- R1: A synchronous active-high reset clears the output valid, the overflow flag and the held group exponent to zero.
- R2: A word presented with `in_valid` high appears on the output exactly two cycles later, with `out_valid` high and `out_imag` equal to its `in_imag`. No output is valid two cycles after an idle input cycle.
- R3: For a real word, the right-shift count is `univ_exp - (group exponent + in_tag)` when that difference lies in 0..15.
- R4: The shift is arithmetic: the sign bit fills the vacated upper bits, so the output keeps the sign of the input, or becomes zero.
- R5: When the difference exceeds 15, the shift is forced to 15 places. A negative word then gives 0xFFFF and a positive word gives 0x0000.
- R6: When the word exponent exceeds `univ_exp`, the word passes unshifted and `overflow` is set one cycle after the word is accepted.
- R7: Once set, `overflow` stays high until reset, whatever words follow.
- R8: An imaginary word (`in_imag`=1) uses the shift count of the most recent real word. Its own `in_tag` is ignored.
- R9: `grp_load` captures `grp_exp_in`. Words accepted from the next cycle onward use the captured value until the next strobe.
- R10: When the word exponent equals `univ_exp`, the word passes unchanged and no overflow is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word valid |
| in_imag | input | 1 | 0 = real word, 1 = imaginary word |
| in_data | input | 16 | Two's-complement input word |
| in_tag | input | 2 | Per-sample word tag, used with real words |
| grp_load | input | 1 | Strobe that captures the group exponent |
| grp_exp_in | input | 5 | Group exponent of the current transform |
| univ_exp | input | 5 | Universal (target) exponent, already incremented by one |
| out_valid | output | 1 | Output word valid |
| out_imag | output | 1 | Real/imaginary marker of the output word |
| out_data | output | 16 | Normalised output word |
| overflow | output | 1 | Sticky flag: a word exponent exceeded the universal exponent |

## Verification
The bench targets the edges of the shift range. It checks a difference of exactly 0, a difference of 16 that must clamp to 15, and a negative difference that must give zero shift and the sticky flag. A design with a wrapping 4-bit subtractor would shift by 0 or a small count in the clamp case, and by a large count in the negative case. It drives negative words, which expose a logical shift through zero-filled upper bits. It also feeds imaginary words with a tag that differs from the real word's tag; a design that uses that tag shifts the imaginary word by the wrong amount. Finally, it loads the group exponent between transforms and checks that the value holds across samples and that the flag survives later clean words.

// File: rtl/bfp_norm_pkg.sv
package bfp_norm_pkg;
    parameter int DATA_W = 16;
    parameter int TAG_W  = 2;
    parameter int GEXP_W = 5;
    parameter int SH_W   = 4;

    localparam int MAX_SHIFT = (1 << SH_W) - 1;
    localparam int SH_STAGES = SH_W;

    typedef logic signed [DATA_W-1:0] word_t;
    typedef logic [SH_W-1:0]          shamt_t;
    typedef logic [TAG_W-1:0]         tag_t;
    typedef logic [GEXP_W-1:0]        gexp_t;

    typedef enum logic [1:0] {
        SC_IN_RANGE = 2'd0,
        SC_CLAMPED  = 2'd1,
        SC_UNDER    = 2'd2
    } shift_class_e;

    typedef struct packed {
        shamt_t       amount;
        shift_class_e cls;
    } shift_res_t;

    typedef struct packed {
        logic   valid;
        logic   imag;
        word_t  data;
        shamt_t shamt;
    } stage_t;

    // Shift count from universal exponent minus (group + tag), clamped.
    function automatic shift_res_t calc_shift(gexp_t grp, tag_t tag, gexp_t univ);
        shift_res_t r;
        int         d;
        d = int'(univ) - int'(grp) - int'(tag);
        if (d < 0) begin
            r.amount = '0;
            r.cls    = SC_UNDER;
        end else if (d > MAX_SHIFT) begin
            r.amount = shamt_t'(MAX_SHIFT);
            r.cls    = SC_CLAMPED;
        end else begin
            r.amount = shamt_t'(d);
            r.cls    = SC_IN_RANGE;
        end
        return r;
    endfunction
endpackage

// File: rtl/bfp_exp_unit.sv
module bfp_exp_unit
    import bfp_norm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   grp_load,
    input  gexp_t  grp_in,
    input  gexp_t  univ,
    input  logic   in_valid,
    input  logic   in_imag,
    input  tag_t   in_tag,
    output shamt_t shamt,
    output gexp_t  grp_q,
    output logic   ovf
);
    shamt_t     held_shamt;
    shift_res_t res;

    always_comb begin
        res   = calc_shift(grp_q, in_tag, univ);
        shamt = in_imag ? held_shamt : res.amount;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            grp_q      <= '0;
            held_shamt <= '0;
            ovf        <= 1'b0;
        end else begin
            if (grp_load)
                grp_q <= grp_in;
            if (in_valid && !in_imag) begin
                held_shamt <= res.amount;
                if (res.cls == SC_UNDER)
                    ovf <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/bfp_shifter.sv
module bfp_shifter
    import bfp_norm_pkg::*;
(
    input  word_t  din,
    input  shamt_t sh,
    output word_t  dout
);
    word_t stg [SH_STAGES+1];

    assign stg[0] = din;

    generate
        for (genvar i = 0; i < SH_STAGES; i++) begin : g_stage
            assign stg[i+1] = sh[i] ? (stg[i] >>> (1 << i)) : stg[i];
        end
    endgenerate

    assign dout = stg[SH_STAGES];
endmodule

// File: rtl/bfp_out_norm.sv
module bfp_out_norm
    import bfp_norm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic        in_imag,
    input  logic [15:0] in_data,
    input  logic [1:0]  in_tag,
    input  logic        grp_load,
    input  logic [4:0]  grp_exp_in,
    input  logic [4:0]  univ_exp,
    output logic        out_valid,
    output logic        out_imag,
    output logic [15:0] out_data,
    output logic        overflow
);
    shamt_t cur_shamt;
    gexp_t  grp_q;
    stage_t s1;
    word_t  shifted;

    bfp_exp_unit u_exp (
        .clk      (clk),
        .rst      (rst),
        .grp_load (grp_load),
        .grp_in   (grp_exp_in),
        .univ     (univ_exp),
        .in_valid (in_valid),
        .in_imag  (in_imag),
        .in_tag   (in_tag),
        .shamt    (cur_shamt),
        .grp_q    (grp_q),
        .ovf      (overflow)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
        end else begin
            s1.valid <= in_valid;
            s1.imag  <= in_imag;
            s1.data  <= word_t'(in_data);
            s1.shamt <= cur_shamt;
        end
    end

    bfp_shifter u_shift (
        .din  (s1.data),
        .sh   (s1.shamt),
        .dout (shifted)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_imag  <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= s1.valid;
            out_imag  <= s1.imag;
            out_data  <= shifted;
        end
    end
endmodule

// File: rtl/bfp_norm_chk.sv
module bfp_norm_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_imag,
    input logic [15:0] in_data,
    input logic [1:0]  in_tag,
    input logic [4:0]  univ_exp,
    input logic [4:0]  grp_q,
    input logic        out_valid,
    input logic        out_imag,
    input logic [15:0] out_data,
    input logic        overflow
);
    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##2 out_valid); // R2
    AST_IDLE_LATENCY: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> ##2 !out_valid); // R2
    AST_MARKER_CARRY: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##2 (out_imag == $past(in_imag, 2))); // R2
    AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##2 (out_data[15] == $past(in_data[15], 2))); // R4
    AST_OVF_RAISE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_imag &&
         (({1'b0, grp_q} + {4'b0, in_tag}) > {1'b0, univ_exp})) |=> overflow); // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow); // R7
endmodule

bind bfp_out_norm bfp_norm_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_imag   (in_imag),
    .in_data   (in_data),
    .in_tag    (in_tag),
    .univ_exp  (univ_exp),
    .grp_q     (grp_q),
    .out_valid (out_valid),
    .out_imag  (out_imag),
    .out_data  (out_data),
    .overflow  (overflow)
);

// File: tb/tb_bfp_out_norm.sv
module tb_bfp_out_norm;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_imag = 1'b0;
    logic [15:0] in_data = '0;
    logic [1:0]  in_tag = '0;
    logic        grp_load = 1'b0;
    logic [4:0]  grp_exp_in = '0;
    logic [4:0]  univ_exp = '0;
    logic        out_valid, out_imag, overflow;
    logic [15:0] out_data;

    int checks = 0;
    int errors = 0;
    int model_grp = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    bfp_out_norm dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_imag(in_imag),
        .in_data(in_data), .in_tag(in_tag), .grp_load(grp_load),
        .grp_exp_in(grp_exp_in), .univ_exp(univ_exp), .out_valid(out_valid),
        .out_imag(out_imag), .out_data(out_data), .overflow(overflow)
    );

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference: clamp to 0..15, zero shift if negative, arithmetic shift.
    function automatic logic [15:0] ref_out(logic [15:0] d, int grp, int tag, int univ);
        int s;
        s = univ - grp - tag;
        if (s < 0) s = 0;
        if (s > 15) s = 15;
        return 16'($signed(d) >>> s);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        grp_load = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_grp = 0;
    endtask

    task automatic load_grp(int g);
        @(negedge clk);
        grp_load = 1'b1;
        grp_exp_in = 5'(g);
        @(negedge clk);
        grp_load = 1'b0;
        model_grp = g;
    endtask

    // Real word then imaginary word; check latency, markers and data.
    task automatic run_pair(string req, logic [15:0] re, logic [15:0] im,
                            int tre, int tim);
        logic [15:0] er, ei;
        er = ref_out(re, model_grp, tre, int'(univ_exp));
        ei = ref_out(im, model_grp, tre, int'(univ_exp));
        @(negedge clk);
        in_valid = 1'b1; in_imag = 1'b0; in_data = re; in_tag = 2'(tre);
        @(negedge clk);
        in_imag = 1'b1; in_data = im; in_tag = 2'(tim);
        chk("R2 early valid", {15'b0, out_valid}, 16'd0);
        @(negedge clk);
        in_valid = 1'b0; in_imag = 1'b0;
        chk("R2 valid real", {15'b0, out_valid}, 16'd1);
        chk("R2 marker real", {15'b0, out_imag}, 16'd0);
        chk({req, " real"}, out_data, er);
        @(negedge clk);
        chk("R2 valid imag", {15'b0, out_valid}, 16'd1);
        chk("R2 marker imag", {15'b0, out_imag}, 16'd1);
        chk({req, " imag"}, out_data, ei);
        @(negedge clk);
        chk("R2 idle", {15'b0, out_valid}, 16'd0);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 valid", {15'b0, out_valid}, 16'd0);
        chk("R1 ovf", {15'b0, overflow}, 16'd0);
        univ_exp = 5'd3;
        run_pair("R1 group cleared", 16'h4000, 16'hC000, 0, 0);
        chk("R1 group shift", out_data, 16'hF800);
    endtask

    task automatic t_basic();
        load_grp(4);
        univ_exp = 5'd10;
        run_pair("R3 shift4", 16'h1234, 16'h7FF0, 2, 2);
        univ_exp = 5'd7;
        run_pair("R3 shift1", 16'h0F0F, 16'h0002, 2, 2);
    endtask

    task automatic t_sign();
        univ_exp = 5'd10;
        run_pair("R4 negative", 16'h8000, 16'hFFF1, 2, 2);
        chk("R4 sign fill", out_data, 16'hFFFF);
    endtask

    task automatic t_clamp();
        load_grp(0);
        univ_exp = 5'd16;
        run_pair("R5 diff16", 16'h8000, 16'h7FFF, 0, 0);
        univ_exp = 5'd31;
        run_pair("R5 diff31", 16'h7FFF, 16'h8001, 0, 0);
        univ_exp = 5'd15;
        run_pair("R5 diff15", 16'hC000, 16'h4000, 0, 0);
    endtask

    task automatic t_equal();
        load_grp(5);
        univ_exp = 5'd6;
        run_pair("R10 unchanged", 16'hA5A5, 16'h5A5A, 1, 1);
        chk("R10 no ovf", {15'b0, overflow}, 16'd0);
    endtask

    task automatic t_imag_tag();
        load_grp(2);
        univ_exp = 5'd12;
        run_pair("R8 imag ignores tag", 16'h4000, 16'h4000, 0, 3);
        run_pair("R8 imag ignores tag b", 16'h2000, 16'h8000, 3, 0);
    endtask

    task automatic t_grp_hold();
        load_grp(1);
        univ_exp = 5'd9;
        run_pair("R9 first", 16'h7000, 16'h0700, 0, 0);
        run_pair("R9 held", 16'h1000, 16'hF000, 1, 1);
        load_grp(6);
        run_pair("R9 new", 16'h7000, 16'h9000, 0, 0);
    endtask

    task automatic t_overflow();
        do_reset();
        load_grp(10);
        univ_exp = 5'd12;
        run_pair("R6 no shift", 16'h8765, 16'h1234, 3, 3);
        chk("R6 ovf set", {15'b0, overflow}, 16'd1);
        univ_exp = 5'd20;
        run_pair("R7 later clean", 16'h4000, 16'h4000, 0, 0);
        chk("R7 ovf held", {15'b0, overflow}, 16'd1);
        do_reset();
        chk("R1 ovf cleared", {15'b0, overflow}, 16'd0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_basic();
        t_sign();
        t_clamp();
        t_equal();
        t_imag_tag();
        t_grp_hold();
        t_overflow();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end
endmodule